// File: doc/BRIEF.md
# Multi-Window Readout Address Sequencer

This block produces the row and column-kernel addresses that drive the readout of an image array through one to four programmable rectangular windows. Each window has a first row, a last row, a first kernel and a kernel count. A frame-start pulse captures the whole configuration. The sequencer then walks the active windows one at a time in ascending index order. It scans each window row by row and emits at most one address pair per clock, with markers for the end of a row, the end of a window and the end of the frame.

Two flags reverse the scan order, one for columns and one for rows. A subsampling mode drops rows and columns using one of two patterns. The pattern phase is counted from the first row and the first kernel scanned in each window. A capture-enable input gates the readout: while it is low, the walk holds its place. A window that is badly programmed is skipped and a sticky error flag is raised.

Top module: `win_addr_seq`

## Requirements
- R1: `win_cnt` selects how many windows are active: 0 selects window 1 only, 1 selects windows 1–2, 2 selects windows 1–3, and 3 selects all four. Active windows are read in ascending index order, and each finishes before the next starts.
- R2: With no reversal and no subsampling, a window yields every row from its Y start to its Y end. Within each row it yields the kernels from its X start for its kernel count. Addresses come row-major, one per cycle, and column addresses wrap modulo 2^XW.
- R3: When `rev_x` is 1, each row's kernels come from the highest kernel (X start + count − 1) down to X start.
- R4: When `rev_y` is 1, each window's rows come from Y end down to Y start.
- R5: When `sub_en` is 1 and `sub_color` is 0, scan positions 0, 2, 4, … are read along each axis and the rest are skipped. A position is its 0-based distance from the first row or kernel scanned in the window.
- R6: When `sub_en` is 1 and `sub_color` is 1, positions whose index modulo 4 is 0 or 1 are read along each axis. The position count restarts at 0 in every window.
- R7: `end_row` is 1 with the last address of each row. `end_win` is 1 with the last address of each window that produces addresses.
- R8: `end_frame` is 1 with the last address of the last window that produces addresses. In that same cycle `busy` reads 0.
- R9: Readout advances only while `capture_en` is 1. While it is 0, no address is produced and the walk resumes where it stopped. A `frame_start` is ignored while `capture_en` is 0 or a frame is in progress.
- R10: An active window whose Y end is below its Y start, or whose kernel count is 0, produces no addresses. Such a window sets `cfg_err`, which stays 1 until reset.
- R11: After reset, `addr_valid`, all markers, `busy` and `cfg_err` are 0.
- R12: Every configuration input is captured at the accepted `frame_start`. Later changes have no effect on the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle pulse starting a frame |
| capture_en | input | 1 | Readout runs only while 1 |
| win_cnt | input | CW | Active window count minus one |
| cfg_ystart | input | NWIN*YW | Per-window first row, window i at bits [i*YW +: YW] |
| cfg_yend | input | NWIN*YW | Per-window last row |
| cfg_xstart | input | NWIN*XW | Per-window first kernel |
| cfg_xkern | input | NWIN*XW | Per-window kernel count |
| rev_x | input | 1 | Reverse column scan |
| rev_y | input | 1 | Reverse row scan |
| sub_en | input | 1 | Subsampling enable |
| sub_color | input | 1 | Pattern: 0 read-one-skip-one, 1 read-two-skip-two |
| addr_valid | output | 1 | Address pair valid this cycle |
| row_addr | output | YW | Row address |
| col_addr | output | XW | Kernel address |
| end_row | output | 1 | Last address of a row |
| end_win | output | 1 | Last address of a window |
| end_frame | output | 1 | Last address of the frame |
| busy | output | 1 | Frame walk in progress |
| cfg_err | output | 1 | Sticky bad-window flag |

## Verification
The assertions check on every cycle how the markers nest within one another: a window end is also a row end, and a frame end is also a window end, comes with a valid address and comes with busy low. They also check that an address never follows a cycle with capture disabled, that busy rises only after an accepted start, and that the error flag never falls. Only the bench scenarios can show the address order itself: the window order, both reversals, both skip patterns with their per-window phase restart, column wrap, pause and resume, and immunity to mid-frame configuration changes. The bench checks each of these against a sequence it builds from the requirements.

// File: rtl/wseq_pkg.sv
package wseq_pkg;
  typedef enum logic {S_IDLE, S_RUN} wseq_state_e;

  // distance to the next read position along one axis
  function automatic logic [1:0] skip_step(input logic en, input logic colour,
                                           input logic odd);
    if (!en) return 2'd1;
    if (!colour) return 2'd2;
    return odd ? 2'd3 : 2'd1;
  endfunction
endpackage

// File: rtl/wseq_win_chk.sv
module wseq_win_chk #(
  parameter int YW = 10,
  parameter int XW = 6
) (
  input  logic [YW-1:0] y_start,
  input  logic [YW-1:0] y_end,
  input  logic [XW-1:0] kern,
  output logic          ok
);
  assign ok = (y_end >= y_start) && (kern != '0);
endmodule

// File: rtl/wseq_axis.sv
module wseq_axis #(
  parameter int AW = 10,
  parameter int LW = 11
) (
  input  logic [LW-1:0] idx,
  input  logic [LW-1:0] len,
  input  logic [AW-1:0] base,
  input  logic          rev,
  input  logic          sub_en,
  input  logic          sub_col,
  output logic [AW-1:0] addr,
  output logic [LW-1:0] nxt,
  output logic          last
);
  import wseq_pkg::*;

  logic [1:0]    step;
  logic [LW:0]   step_sum;
  logic [LW-1:0] offs;

  always_comb begin
    step     = skip_step(sub_en, sub_col, idx[0]);
    step_sum = {1'b0, idx} + (LW+1)'(step);
    last     = step_sum >= {1'b0, len};
    nxt      = step_sum[LW-1:0];
    offs     = rev ? (len - idx - LW'(1)) : idx;
    addr     = base + offs[AW-1:0];
  end
endmodule

// File: rtl/win_addr_seq.sv
module win_addr_seq #(
  parameter int NWIN = 4,
  parameter int YW   = 10,
  parameter int XW   = 6,
  localparam int CW  = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              capture_en,
  input  logic [CW-1:0]     win_cnt,
  input  logic [NWIN*YW-1:0] cfg_ystart,
  input  logic [NWIN*YW-1:0] cfg_yend,
  input  logic [NWIN*XW-1:0] cfg_xstart,
  input  logic [NWIN*XW-1:0] cfg_xkern,
  input  logic              rev_x,
  input  logic              rev_y,
  input  logic              sub_en,
  input  logic              sub_color,
  output logic              addr_valid,
  output logic [YW-1:0]     row_addr,
  output logic [XW-1:0]     col_addr,
  output logic              end_row,
  output logic              end_win,
  output logic              end_frame,
  output logic              busy,
  output logic              cfg_err
);
  import wseq_pkg::*;

  localparam int RLW = YW + 1;
  localparam int CLW = XW + 1;

  wseq_state_e     st_q;
  logic [CW-1:0]   win_q;
  logic [RLW-1:0]  ridx_q, ridx_n, row_len;
  logic [CLW-1:0]  cidx_q, cidx_n, col_len;
  logic [YW-1:0]   ys_q [NWIN];
  logic [YW-1:0]   ye_q [NWIN];
  logic [XW-1:0]   xs_q [NWIN];
  logic [XW-1:0]   xk_q [NWIN];
  logic            rev_x_q, rev_y_q, sub_en_q, sub_col_q;
  logic [NWIN-1:0] ok_now, act_now, run_mask_q;
  logic            start, later, row_last, col_last;
  logic [YW-1:0]   row_a;
  logic [XW-1:0]   col_a;

  for (genvar g = 0; g < NWIN; g++) begin : g_chk
    wseq_win_chk #(.YW(YW), .XW(XW)) u_win_chk (
      .y_start (cfg_ystart[g*YW +: YW]),
      .y_end   (cfg_yend[g*YW +: YW]),
      .kern    (cfg_xkern[g*XW +: XW]),
      .ok      (ok_now[g])
    );
  end

  always_comb begin
    for (int i = 0; i < NWIN; i++) act_now[i] = (i <= int'(win_cnt));
    later = 1'b0;
    for (int i = 0; i < NWIN; i++)
      if (run_mask_q[i] && (i > int'(win_q))) later = 1'b1;
  end

  assign start   = frame_start && capture_en && (st_q == S_IDLE);
  assign row_len = {1'b0, ye_q[win_q]} - {1'b0, ys_q[win_q]} + RLW'(1);
  assign col_len = {1'b0, xk_q[win_q]};
  assign busy    = (st_q == S_RUN);

  wseq_axis #(.AW(YW), .LW(RLW)) u_row_axis (
    .idx(ridx_q), .len(row_len), .base(ys_q[win_q]), .rev(rev_y_q),
    .sub_en(sub_en_q), .sub_col(sub_col_q),
    .addr(row_a), .nxt(ridx_n), .last(row_last)
  );

  wseq_axis #(.AW(XW), .LW(CLW)) u_col_axis (
    .idx(cidx_q), .len(col_len), .base(xs_q[win_q]), .rev(rev_x_q),
    .sub_en(sub_en_q), .sub_col(sub_col_q),
    .addr(col_a), .nxt(cidx_n), .last(col_last)
  );

  // configuration snapshot, no reset needed
  always_ff @(posedge clk) begin
    if (start) begin
      for (int i = 0; i < NWIN; i++) begin
        ys_q[i] <= cfg_ystart[i*YW +: YW];
        ye_q[i] <= cfg_yend[i*YW +: YW];
        xs_q[i] <= cfg_xstart[i*XW +: XW];
        xk_q[i] <= cfg_xkern[i*XW +: XW];
      end
      rev_x_q   <= rev_x;
      rev_y_q   <= rev_y;
      sub_en_q  <= sub_en;
      sub_col_q <= sub_color;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= S_IDLE;
      win_q      <= '0;
      ridx_q     <= '0;
      cidx_q     <= '0;
      run_mask_q <= '0;
      cfg_err    <= 1'b0;
      addr_valid <= 1'b0;
      row_addr   <= '0;
      col_addr   <= '0;
      end_row    <= 1'b0;
      end_win    <= 1'b0;
      end_frame  <= 1'b0;
    end else begin
      addr_valid <= 1'b0;
      end_row    <= 1'b0;
      end_win    <= 1'b0;
      end_frame  <= 1'b0;
      case (st_q)
        S_IDLE: begin
          if (start) begin
            st_q       <= S_RUN;
            win_q      <= '0;
            ridx_q     <= '0;
            cidx_q     <= '0;
            run_mask_q <= ok_now & act_now;
            if (|(act_now & ~ok_now)) cfg_err <= 1'b1;
          end
        end
        S_RUN: begin
          if (capture_en) begin
            if (!run_mask_q[win_q]) begin
              ridx_q <= '0;
              cidx_q <= '0;
              if (later) win_q <= win_q + CW'(1);
              else       st_q  <= S_IDLE;
            end else begin
              addr_valid <= 1'b1;
              row_addr   <= row_a;
              col_addr   <= col_a;
              end_row    <= col_last;
              end_win    <= col_last && row_last;
              end_frame  <= col_last && row_last && !later;
              if (col_last) begin
                cidx_q <= '0;
                if (row_last) begin
                  ridx_q <= '0;
                  if (later) win_q <= win_q + CW'(1);
                  else       st_q  <= S_IDLE;
                end else begin
                  ridx_q <= ridx_n;
                end
              end else begin
                cidx_q <= cidx_n;
              end
            end
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wseq_chk.sv
module wseq_chk (
  input logic clk,
  input logic rst,
  input logic frame_start,
  input logic capture_en,
  input logic addr_valid,
  input logic end_row,
  input logic end_win,
  input logic end_frame,
  input logic busy,
  input logic cfg_err
);
  // R7
  win_end_is_row_end_chk: assert property (@(posedge clk) disable iff (rst)
    end_win |-> end_row);

  // R7
  row_end_has_addr_chk: assert property (@(posedge clk) disable iff (rst)
    end_row |-> addr_valid);

  // R8
  frame_end_closes_chk: assert property (@(posedge clk) disable iff (rst)
    end_frame |-> (end_win && addr_valid && !busy));

  // R9
  no_addr_when_gated_chk: assert property (@(posedge clk) disable iff (rst)
    addr_valid |-> $past(capture_en));

  // R9
  busy_needs_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(frame_start && capture_en));

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> cfg_err);
endmodule

bind win_addr_seq wseq_chk u_wseq_chk (
  .clk(clk), .rst(rst), .frame_start(frame_start), .capture_en(capture_en),
  .addr_valid(addr_valid), .end_row(end_row), .end_win(end_win),
  .end_frame(end_frame), .busy(busy), .cfg_err(cfg_err)
);

// File: tb/win_addr_seq_bench.sv
module win_addr_seq_bench;
  localparam int NW = 4, YW = 10, XW = 6, CW = 2;

  logic clk = 1'b0, rst = 1'b1, frame_start = 1'b0, capture_en = 1'b1;
  logic [CW-1:0] b_cnt = '0;
  logic [YW-1:0] b_ys [NW];
  logic [YW-1:0] b_ye [NW];
  logic [XW-1:0] b_xs [NW];
  logic [XW-1:0] b_xk [NW];
  logic b_rx = 0, b_ry = 0, b_sub = 0, b_col = 0;
  logic [NW*YW-1:0] ys_bus, ye_bus;
  logic [NW*XW-1:0] xs_bus, xk_bus;
  logic addr_valid, end_row, end_win, end_frame, busy, cfg_err;
  logic [YW-1:0] row_addr;
  logic [XW-1:0] col_addr;

  for (genvar g = 0; g < NW; g++) begin : g_pack
    assign ys_bus[g*YW +: YW] = b_ys[g];
    assign ye_bus[g*YW +: YW] = b_ye[g];
    assign xs_bus[g*XW +: XW] = b_xs[g];
    assign xk_bus[g*XW +: XW] = b_xk[g];
  end

  always #4 clk = ~clk;

  win_addr_seq u_win_addr_seq (
    .clk(clk), .rst(rst), .frame_start(frame_start), .capture_en(capture_en),
    .win_cnt(b_cnt), .cfg_ystart(ys_bus), .cfg_yend(ye_bus),
    .cfg_xstart(xs_bus), .cfg_xkern(xk_bus), .rev_x(b_rx), .rev_y(b_ry),
    .sub_en(b_sub), .sub_color(b_col), .addr_valid(addr_valid),
    .row_addr(row_addr), .col_addr(col_addr), .end_row(end_row),
    .end_win(end_win), .end_frame(end_frame), .busy(busy), .cfg_err(cfg_err)
  );

  int n_chk = 0, n_bad = 0, cyc_total = 0;
  bit done = 0;
  int n_exp;
  logic [YW-1:0] e_row [2048];
  logic [XW-1:0] e_col [2048];
  logic e_er [2048];
  logic e_ew [2048];
  logic e_ef [2048];

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic bit keep(input int i);
    if (!b_sub) return 1;
    if (b_col) return (i % 4) < 2;
    return (i % 2) == 0;
  endfunction

  // expected sequence built straight from the requirements
  task automatic build_expected();
    n_exp = 0;
    for (int w = 0; w <= int'(b_cnt); w++) begin
      int ys = int'(b_ys[w]), ye = int'(b_ye[w]);
      int xs = int'(b_xs[w]), xk = int'(b_xk[w]);
      if (ye < ys || xk == 0) continue;
      for (int r = 0; r <= ye - ys; r++) begin
        if (!keep(r)) continue;
        for (int c = 0; c < xk; c++) begin
          if (!keep(c)) continue;
          e_row[n_exp] = YW'(b_ry ? ye - r : ys + r);
          e_col[n_exp] = XW'(b_rx ? xs + xk - 1 - c : xs + c);
          e_er[n_exp] = 0; e_ew[n_exp] = 0; e_ef[n_exp] = 0;
          n_exp++;
        end
        e_er[n_exp-1] = 1;
      end
      e_ew[n_exp-1] = 1;
    end
    if (n_exp > 0) e_ef[n_exp-1] = 1;
  endtask

  task automatic set_win(input int w, input int ys, input int ye,
                         input int xs, input int xk);
    b_ys[w] = YW'(ys); b_ye[w] = YW'(ye); b_xs[w] = XW'(xs); b_xk[w] = XW'(xk);
  endtask

  task automatic run_frame(input string tag, input int pause_at,
                           input int pause_len, input bit disturb);
    int k = 0, tail = 0;
    bit prev_cap;
    logic [CW-1:0] s_cnt; logic s_rx;
    build_expected();
    s_cnt = b_cnt; s_rx = b_rx;
    @(negedge clk) frame_start = 1;
    @(negedge clk) frame_start = 0;
    for (int cyc = 0; cyc < 6000 && tail < 10; cyc++) begin
      prev_cap = capture_en;
      @(negedge clk);
      if (addr_valid) begin
        if (!prev_cap) check(0, "R9", "address while gated", 1, 0);
        if (k < n_exp) begin
          check(row_addr == e_row[k] && col_addr == e_col[k] &&
                end_row == e_er[k] && end_win == e_ew[k] && end_frame == e_ef[k],
                tag, $sformatf("item %0d row/col/er/ew/ef", k),
                {row_addr, col_addr, end_row, end_win, end_frame},
                {e_row[k], e_col[k], e_er[k], e_ew[k], e_ef[k]});
          if (e_ef[k]) check(!busy, "R8", "busy at frame end", busy, 0);
        end else check(0, tag, "extra address", k, n_exp);
        k++;
      end
      if (k >= n_exp && !busy) tail++;
      capture_en = !(cyc >= pause_at && cyc < pause_at + pause_len);
      if (disturb && cyc == 3) begin
        b_rx = ~b_rx; b_cnt = ~b_cnt; frame_start = 1;
      end
      if (disturb && cyc == 4) frame_start = 0;
    end
    capture_en = 1;
    b_cnt = s_cnt; b_rx = s_rx;
    check(k == n_exp, tag, "address count", k, n_exp);
    check(!busy, tag, "idle after frame", busy, 0);
  endtask

  task automatic t_reset();
    check(!addr_valid && !end_row && !end_win && !end_frame, "R11",
          "outputs after reset", {addr_valid, end_row, end_win, end_frame}, 0);
    check(!busy && !cfg_err, "R11", "busy/err after reset", {busy, cfg_err}, 0);
  endtask

  task automatic base_cfg();
    set_win(0, 5, 9, 10, 4);
    set_win(1, 20, 22, 0, 3);
    set_win(2, 100, 104, 30, 5);
    set_win(3, 1000, 1023, 60, 2);
    b_rx = 0; b_ry = 0; b_sub = 0; b_col = 0;
  endtask

  task automatic t_plain();
    base_cfg(); b_cnt = 0; run_frame("R2", 9999, 0, 0);
    set_win(0, 7, 8, 62, 4); run_frame("R2", 9999, 0, 0);   // column wrap
  endtask

  task automatic t_multi();
    base_cfg(); b_cnt = 3; run_frame("R1", 9999, 0, 0);
    b_cnt = 1; run_frame("R1", 9999, 0, 0);
    b_cnt = 2; run_frame("R1", 9999, 0, 0);
  endtask

  task automatic t_reverse();
    base_cfg(); b_cnt = 2; b_rx = 1; run_frame("R3", 9999, 0, 0);
    b_rx = 0; b_ry = 1; run_frame("R4", 9999, 0, 0);
    b_rx = 1; run_frame("R4", 9999, 0, 0);
  endtask

  task automatic t_subsample();
    base_cfg(); b_cnt = 3; b_sub = 1; b_col = 0; run_frame("R5", 9999, 0, 0);
    b_ry = 1; b_rx = 1; run_frame("R5", 9999, 0, 0);
    base_cfg(); b_cnt = 3; b_sub = 1; b_col = 1;
    set_win(0, 3, 11, 1, 7);
    set_win(1, 40, 45, 8, 6);
    run_frame("R6", 9999, 0, 0);
    b_rx = 1; run_frame("R6", 9999, 0, 0);
  endtask

  task automatic t_markers();
    base_cfg(); b_cnt = 3; set_win(1, 50, 54, 9, 1); set_win(2, 60, 60, 2, 5);
    run_frame("R7", 9999, 0, 0);
  endtask

  task automatic t_gate();
    base_cfg(); b_cnt = 3; run_frame("R9", 6, 7, 0);
    capture_en = 0;
    @(negedge clk) frame_start = 1;
    @(negedge clk) frame_start = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      check(!addr_valid && !busy, "R9", "start ignored while gated",
            {addr_valid, busy}, 0);
    end
    capture_en = 1;
  endtask

  task automatic t_latch();
    base_cfg(); b_cnt = 3; run_frame("R12", 9999, 0, 1);
  endtask

  task automatic t_errors();
    check(!cfg_err, "R10", "no error before bad window", cfg_err, 0);
    base_cfg(); b_cnt = 3; set_win(1, 30, 29, 0, 3); set_win(2, 5, 6, 4, 0);
    run_frame("R10", 9999, 0, 0);
    check(cfg_err, "R10", "error flagged", cfg_err, 1);
    base_cfg(); b_cnt = 0; set_win(0, 9, 8, 1, 1);
    run_frame("R10", 9999, 0, 0);
    base_cfg(); b_cnt = 0; run_frame("R10", 9999, 0, 0);
    check(cfg_err, "R10", "error stays set", cfg_err, 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 150000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below %0d", cyc_total, 150000);
      finish_run();
    end
  end

  initial begin
    base_cfg();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_plain();
    t_multi();
    t_reverse();
    t_subsample();
    t_markers();
    t_gate();
    t_latch();
    t_errors();
    finish_run();
  end
endmodule